// File: doc/BRIEF.md
# Tag-Renaming Reservation Station Array

This block holds a small pool of reservation stations in front of one execution unit and removes false register dependences by renaming. A rename table keeps, for every architectural register, either a committed value or the tag of the station that will produce its next value. The tag is the station's slot number. When an instruction is dispatched, each source is resolved against the table. A free register hands over its value. A pending register hands over the producer's tag. The destination entry is then pointed at the new station's tag, so a register that already has a write in flight does not block dispatch.

Results return on a single broadcast bus that carries a tag and a data word. Every station with a not-ready source watches the bus and takes the data when the tags match. The rename table writes the data back only while the register still names that producer. A station whose operands are all present issues to the unit when the unit reports itself free. The lowest-numbered ready station wins. The station is released as it issues.

The producing unit must broadcast a station's result before that slot number is dispatched again. A read port shows one register's busy flag, tag and value, one cycle after the address is presented.

Top module: `tag_rename_stations`

## Requirements
- R1: An instruction is accepted while any station is free, even when its destination register already has a pending write.
- R2: A source register that is not busy at dispatch is stored in the station as its current value and marked ready.
- R3: A source register that is busy at dispatch is stored as the producer tag and marked not ready. The station cannot issue until that source is filled.
- R4: On dispatch the station taken is the lowest-numbered free slot. In the cycle after dispatch, the destination register reads as busy with that slot number as its tag.
- R5: A broadcast whose tag equals a not-ready source's tag fills that source with the broadcast data and marks it ready.
- R6: When unit_free is high, the lowest-numbered station with every source ready issues. Its tag, opcode and operands appear on the issue outputs with issue_valid in the following cycle. Nothing issues while unit_free is low.
- R7: A broadcast writes a register's value and clears its busy flag only if the register's current tag equals the broadcast tag. Otherwise the register stays busy with its tag unchanged.
- R8: While every station is occupied, disp_ready is low and a dispatch request changes no state. A station that issues is free again in the cycle after it issues.
- R9: A broadcast in the same cycle as a dispatch is forwarded. A source whose producer tag matches the broadcast is stored as the broadcast data and marked ready.
- R10: After reset no register is busy, register k holds the value k, every station is free and issue_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | log2(NUM_REGS) | Destination register |
| disp_src_a | input | log2(NUM_REGS) | First source register |
| disp_src_b | input | log2(NUM_REGS) | Second source register |
| disp_ready | output | 1 | At least one station is free |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | log2(NUM_STN) | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result data |
| unit_free | input | 1 | Execution unit can accept an operation |
| issue_valid | output | 1 | An operation was issued |
| issue_tag | output | log2(NUM_STN) | Slot number of the issued station |
| issue_op | output | OP_W | Opcode of the issued operation |
| issue_a | output | DATA_W | First operand |
| issue_b | output | DATA_W | Second operand |
| rd_addr | input | log2(NUM_REGS) | Register to inspect |
| rd_busy | output | 1 | Busy flag of the inspected register |
| rd_tag | output | log2(NUM_STN) | Tag of the inspected register |
| rd_value | output | DATA_W | Value of the inspected register |

## Verification
The hardest situation to reach is a station slot being reused in the same cycle that the result of its previous occupant is broadcast. The new instruction reads the register that the old one is writing, so forwarding, table writeback and the fresh rename all act in that one cycle. The stimulus issues a producer and then, in a single cycle, raises both a dispatch of a consumer that gets the same slot and the broadcast of that slot's tag. The stale-writeback case is reached by renaming a register twice before the first producer's result arrives, and the full-array stall by keeping unit_free low while every slot is filled.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam int DEF_REGS   = 8;
  localparam int DEF_STN    = 4;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_OP_W   = 4;
  localparam int NUM_SRC    = 2;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rename_table.sv
module rename_table #(
  parameter int NUM_REGS = trs_pkg::DEF_REGS,
  parameter int NUM_STN  = trs_pkg::DEF_STN,
  parameter int DATA_W   = trs_pkg::DEF_DATA_W,
  parameter int NSRC     = trs_pkg::NUM_SRC,
  localparam int RA_W    = $clog2(NUM_REGS),
  localparam int TAG_W   = $clog2(NUM_STN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   src_addr [NSRC],
  output logic              src_busy [NSRC],
  output logic [TAG_W-1:0]  src_tag  [NSRC],
  output logic [DATA_W-1:0] src_val  [NSRC],
  input  logic              ren_en,
  input  logic [RA_W-1:0]   ren_dst,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic [RA_W-1:0]   peek_addr,
  output logic              peek_busy,
  output logic [TAG_W-1:0]  peek_tag,
  output logic [DATA_W-1:0] peek_val
);
  logic [DATA_W-1:0] val_q [NUM_REGS];
  logic [TAG_W-1:0]  tag_q [NUM_REGS];
  logic [NUM_REGS-1:0] busy_q;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      src_busy[s] = busy_q[src_addr[s]];
      src_tag[s]  = tag_q[src_addr[s]];
      src_val[s]  = val_q[src_addr[s]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        val_q[i]  <= DATA_W'(i);
        tag_q[i]  <= '0;
        busy_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (cdb_valid && busy_q[i] && (tag_q[i] == cdb_tag)) begin
          val_q[i]  <= cdb_data;
          busy_q[i] <= 1'b0;
        end
        if (ren_en && (ren_dst == RA_W'(i))) begin
          busy_q[i] <= 1'b1;
          tag_q[i]  <= ren_tag;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peek_busy <= 1'b0;
      peek_tag  <= '0;
      peek_val  <= '0;
    end else begin
      peek_busy <= busy_q[peek_addr];
      peek_tag  <= tag_q[peek_addr];
      peek_val  <= val_q[peek_addr];
    end
  end

  p_dst_rename_r4: assert property (@(posedge clk) disable iff (rst)
    ren_en |=> busy_q[$past(ren_dst)] && (tag_q[$past(ren_dst)] == $past(ren_tag)));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg_chk
    p_stale_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && busy_q[g] && (tag_q[g] != cdb_tag) && !(ren_en && ren_dst == RA_W'(g)))
      |=> busy_q[g] && (tag_q[g] == $past(tag_q[g])) && (val_q[g] == $past(val_q[g])));
    p_writeback_r7: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && busy_q[g] && (tag_q[g] == cdb_tag) && !(ren_en && ren_dst == RA_W'(g)))
      |=> !busy_q[g] && (val_q[g] == $past(cdb_data)));
  end
endmodule

// File: rtl/operand_cell.sv
module operand_cell #(
  parameter int DATA_W = trs_pkg::DEF_DATA_W,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_rdy,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [DATA_W-1:0] load_val,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              rdy,
  output logic [DATA_W-1:0] val
);
  logic [TAG_W-1:0] tag_q;
  logic             hit;

  assign hit = cdb_valid && !rdy && (cdb_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy   <= 1'b0;
      tag_q <= '0;
      val   <= '0;
    end else if (load) begin
      rdy   <= load_rdy;
      tag_q <= load_tag;
      val   <= load_val;
    end else if (hit) begin
      rdy <= 1'b1;
      val <= cdb_data;
    end
  end

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !rdy && cdb_valid && (cdb_tag == tag_q)) |=> rdy && (val == $past(cdb_data)));
  p_wait_tag_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !rdy && !(cdb_valid && (cdb_tag == tag_q))) |=> !rdy);
endmodule

// File: rtl/station_slot.sv
module station_slot #(
  parameter int DATA_W = trs_pkg::DEF_DATA_W,
  parameter int OP_W   = trs_pkg::DEF_OP_W,
  parameter int TAG_W  = 2,
  parameter int NSRC   = trs_pkg::NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [NSRC-1:0]   alloc_rdy,
  input  logic [TAG_W-1:0]  alloc_tag [NSRC],
  input  logic [DATA_W-1:0] alloc_val [NSRC],
  input  logic              release_i,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] opnd [NSRC]
);
  logic [NSRC-1:0] src_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      op   <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      op   <= alloc_op;
    end else if (release_i) begin
      busy <= 1'b0;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    operand_cell #(.DATA_W(DATA_W), .TAG_W(TAG_W)) cell_i (
      .clk(clk), .rst(rst), .load(alloc),
      .load_rdy(alloc_rdy[s]), .load_tag(alloc_tag[s]), .load_val(alloc_val[s]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .rdy(src_rdy[s]), .val(opnd[s])
    );
  end

  assign ready = busy && (&src_rdy);

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (release_i && !alloc) |=> !busy);
  p_alloc_free_r1: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !busy);
endmodule

// File: rtl/tag_rename_stations.sv
module tag_rename_stations #(
  parameter int NUM_REGS = trs_pkg::DEF_REGS,
  parameter int NUM_STN  = trs_pkg::DEF_STN,
  parameter int DATA_W   = trs_pkg::DEF_DATA_W,
  parameter int OP_W     = trs_pkg::DEF_OP_W,
  localparam int RA_W    = $clog2(NUM_REGS),
  localparam int TAG_W   = $clog2(NUM_STN),
  localparam int NSRC    = trs_pkg::NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  input  logic [OP_W-1:0]   disp_op,
  input  logic [RA_W-1:0]   disp_dst,
  input  logic [RA_W-1:0]   disp_src_a,
  input  logic [RA_W-1:0]   disp_src_b,
  output logic              disp_ready,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              unit_free,
  output logic              issue_valid,
  output logic [TAG_W-1:0]  issue_tag,
  output logic [OP_W-1:0]   issue_op,
  output logic [DATA_W-1:0] issue_a,
  output logic [DATA_W-1:0] issue_b,
  input  logic [RA_W-1:0]   rd_addr,
  output logic              rd_busy,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_value
);
  logic [RA_W-1:0]   src_addr [NSRC];
  logic              tbl_busy [NSRC];
  logic [TAG_W-1:0]  tbl_tag  [NSRC];
  logic [DATA_W-1:0] tbl_val  [NSRC];
  logic [NSRC-1:0]   cap_rdy;
  logic [TAG_W-1:0]  cap_tag  [NSRC];
  logic [DATA_W-1:0] cap_val  [NSRC];

  logic [NUM_STN-1:0] stn_busy, stn_ready, stn_alloc, stn_release;
  logic [OP_W-1:0]    stn_op  [NUM_STN];
  logic [DATA_W-1:0]  stn_val [NUM_STN][NSRC];

  logic             free_any, rdy_any, disp_fire, iss_fire;
  logic [TAG_W-1:0] free_idx, iss_idx;

  assign src_addr[0] = disp_src_a;
  assign src_addr[1] = disp_src_b;

  rename_table #(.NUM_REGS(NUM_REGS), .NUM_STN(NUM_STN), .DATA_W(DATA_W), .NSRC(NSRC)) table_i (
    .clk(clk), .rst(rst),
    .src_addr(src_addr), .src_busy(tbl_busy), .src_tag(tbl_tag), .src_val(tbl_val),
    .ren_en(disp_fire), .ren_dst(disp_dst), .ren_tag(free_idx),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .peek_addr(rd_addr), .peek_busy(rd_busy), .peek_tag(rd_tag), .peek_val(rd_value)
  );

  // Resolve each source: committed value, same-cycle broadcast, or producer tag.
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      cap_tag[s] = tbl_tag[s];
      if (!tbl_busy[s]) begin
        cap_rdy[s] = 1'b1;
        cap_val[s] = tbl_val[s];
      end else if (cdb_valid && (cdb_tag == tbl_tag[s])) begin
        cap_rdy[s] = 1'b1;
        cap_val[s] = cdb_data;
      end else begin
        cap_rdy[s] = 1'b0;
        cap_val[s] = '0;
      end
    end
  end

  prio_pick #(.N(NUM_STN), .IW(TAG_W)) free_pick_i (
    .req(~stn_busy), .any(free_any), .idx(free_idx));
  prio_pick #(.N(NUM_STN), .IW(TAG_W)) iss_pick_i (
    .req(stn_ready), .any(rdy_any), .idx(iss_idx));

  assign disp_ready = free_any;
  assign disp_fire  = disp_valid && free_any;
  assign iss_fire   = unit_free && rdy_any;

  for (genvar k = 0; k < NUM_STN; k++) begin : g_stn
    assign stn_alloc[k]   = disp_fire && (free_idx == TAG_W'(k));
    assign stn_release[k] = iss_fire && (iss_idx == TAG_W'(k));
    station_slot #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .NSRC(NSRC)) slot_i (
      .clk(clk), .rst(rst),
      .alloc(stn_alloc[k]), .alloc_op(disp_op), .alloc_rdy(cap_rdy),
      .alloc_tag(cap_tag), .alloc_val(cap_val),
      .release_i(stn_release[k]),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .busy(stn_busy[k]), .ready(stn_ready[k]), .op(stn_op[k]), .opnd(stn_val[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_tag   <= '0;
      issue_op    <= '0;
      issue_a     <= '0;
      issue_b     <= '0;
    end else begin
      issue_valid <= iss_fire;
      if (iss_fire) begin
        issue_tag <= iss_idx;
        issue_op  <= stn_op[iss_idx];
        issue_a   <= stn_val[iss_idx][0];
        issue_b   <= stn_val[iss_idx][1];
      end
    end
  end

  p_issue_gate_r6: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> $past(unit_free));
  p_free_after_issue_r8: assert property (@(posedge clk) disable iff (rst)
    iss_fire |=> disp_ready);
  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (!disp_ready && !iss_fire) |=> !disp_ready);
  p_issued_freed_r8: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> !stn_busy[issue_tag] || $past(disp_fire));
endmodule

// File: tb/tag_rename_stations_tb_top.sv
module tag_rename_stations_tb_top;
  localparam int DW = 16;

  typedef struct packed {
    logic [1:0]    tag;
    logic [3:0]    op;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic disp_valid = 1'b0;
  logic [3:0] disp_op = '0;
  logic [2:0] disp_dst = '0, disp_src_a = '0, disp_src_b = '0;
  logic disp_ready;
  logic cdb_valid = 1'b0;
  logic [1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic unit_free = 1'b0;
  logic issue_valid;
  logic [1:0] issue_tag;
  logic [3:0] issue_op;
  logic [DW-1:0] issue_a, issue_b;
  logic [2:0] rd_addr = '0;
  logic rd_busy;
  logic [1:0] rd_tag;
  logic [DW-1:0] rd_value;

  int n_checks = 0;
  int n_fail = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  tag_rename_stations dut_i (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_ready(disp_ready),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .unit_free(unit_free),
    .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b),
    .rd_addr(rd_addr), .rd_busy(rd_busy), .rd_tag(rd_tag), .rd_value(rd_value)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic expect_issue(input logic [1:0] t, input logic [3:0] o,
                              input logic [DW-1:0] a, input logic [DW-1:0] b);
    exp_t e;
    e.tag = t; e.op = o; e.a = a; e.b = b;
    exp_q.push_back(e);
  endtask

  task automatic dispatch(input logic [3:0] o, input logic [2:0] d,
                          input logic [2:0] sa, input logic [2:0] sb);
    @(negedge clk);
    disp_valid = 1'b1; disp_op = o; disp_dst = d; disp_src_a = sa; disp_src_b = sb;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic broadcast(input logic [1:0] t, input logic [DW-1:0] d);
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic free_for(input int n);
    @(negedge clk);
    unit_free = 1'b1;
    repeat (n) @(negedge clk);
    unit_free = 1'b0;
  endtask

  task automatic read_reg(input string req, input logic [2:0] r, input logic b,
                          input logic [1:0] t, input logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = r;
    @(negedge clk);
    chk({req, " busy flag"}, 64'(rd_busy), 64'(b));
    if (b) chk({req, " tag"}, 64'(rd_tag), 64'(t));
    else   chk({req, " value"}, 64'(rd_value), 64'(v));
  endtask

  // Monitor: pop expected issues in order and compare.
  always @(negedge clk) begin
    if (!rst && issue_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R6 unexpected issue: actual tag %0d expected none", issue_tag);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R6 issue tag", 64'(issue_tag), 64'(e.tag));
        chk("R6 issue op", 64'(issue_op), 64'(e.op));
        chk("R6 issue operand a", 64'(issue_a), 64'(e.a));
        chk("R6 issue operand b", 64'(issue_b), 64'(e.b));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 disp_ready after reset", 64'(disp_ready), 64'd1);
    chk("R10 issue_valid after reset", 64'(issue_valid), 64'd0);
    read_reg("R10 r5", 3'd5, 1'b0, 2'd0, 16'd5);

    // Rename a register twice, then let the older result arrive.
    dispatch(4'd1, 3'd1, 3'd2, 3'd3);   // slot0: r1 <- r2,r3 (R2)
    dispatch(4'd2, 3'd4, 3'd1, 3'd1);   // slot1: r4 <- r1,r1 waits on tag 0 (R3)
    dispatch(4'd3, 3'd1, 3'd5, 3'd6);   // slot2: r1 renamed again (R1)
    read_reg("R1 R4 r1 renamed", 3'd1, 1'b1, 2'd2, 16'd0);
    read_reg("R4 r4 renamed", 3'd4, 1'b1, 2'd1, 16'd0);
    chk("R8 disp_ready with one slot free", 64'(disp_ready), 64'd1);
    expect_issue(2'd0, 4'd1, 16'd2, 16'd3);
    expect_issue(2'd2, 4'd3, 16'd5, 16'd6);
    free_for(2);                         // slot1 must be skipped (R3)
    @(negedge clk);
    broadcast(2'd0, 16'd100);            // slot1 captures (R5); r1 ignores (R7)
    read_reg("R7 r1 keeps newer tag", 3'd1, 1'b1, 2'd2, 16'd0);
    expect_issue(2'd1, 4'd2, 16'd100, 16'd100);
    free_for(1);
    @(negedge clk);
    broadcast(2'd2, 16'd77);
    read_reg("R7 r1 written back", 3'd1, 1'b0, 2'd0, 16'd77);
    broadcast(2'd1, 16'd55);
    read_reg("R7 r4 written back", 3'd4, 1'b0, 2'd0, 16'd55);

    // Same-cycle broadcast and dispatch into the reused slot.
    dispatch(4'd4, 3'd7, 3'd0, 3'd0);   // slot0: r7 <- r0,r0
    expect_issue(2'd0, 4'd4, 16'd0, 16'd0);
    free_for(1);
    @(negedge clk);
    disp_valid = 1'b1; disp_op = 4'd5; disp_dst = 3'd2; disp_src_a = 3'd7; disp_src_b = 3'd2;
    cdb_valid = 1'b1; cdb_tag = 2'd0; cdb_data = 16'd200;
    @(negedge clk);
    disp_valid = 1'b0; cdb_valid = 1'b0;
    read_reg("R9 r7 written back", 3'd7, 1'b0, 2'd0, 16'd200);
    read_reg("R4 r2 renamed to slot0", 3'd2, 1'b1, 2'd0, 16'd0);
    expect_issue(2'd0, 4'd5, 16'd200, 16'd2);  // R9 forwarded operand
    free_for(1);
    @(negedge clk);
    broadcast(2'd0, 16'd9);

    // Fill every slot, try one more, then free one.
    dispatch(4'd6, 3'd3, 3'd1, 3'd4);
    dispatch(4'd7, 3'd6, 3'd1, 3'd4);
    dispatch(4'd8, 3'd0, 3'd1, 3'd4);
    dispatch(4'd9, 3'd3, 3'd1, 3'd4);
    chk("R8 disp_ready low when full", 64'(disp_ready), 64'd0);
    dispatch(4'd10, 3'd5, 3'd0, 3'd0);  // must be ignored
    read_reg("R8 r5 untouched by refused dispatch", 3'd5, 1'b0, 2'd0, 16'd5);
    chk("R6 no issue without unit_free", 64'(issue_valid), 64'd0);
    for (int k = 0; k < 4; k++) expect_issue(2'(k), 4'(6 + k), 16'd77, 16'd55);
    free_for(1);
    chk("R8 slot free the cycle after issue", 64'(disp_ready), 64'd1);
    free_for(3);
    repeat (3) @(negedge clk);
    chk("R6 all expected issues seen", 64'(exp_q.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule